// File: doc/BRIEF.md
# AES-128 Round-Key Scheduler with Key Cache

This block expands a 128-bit AES cipher key into the ten round keys the cipher needs. It keeps those keys in a register cache, so later blocks under the same key read them back instead of computing them again. A round datapath starts a block with a one-cycle start pulse. The scheduler then presents the key for round 0, 1, … 10 on eleven consecutive cycles, each tagged with its round index.

The first block after a key write, and the first block after reset, runs the expansion logic in step with the round sequence. Each computed key is written into its cache slot while it is presented. Once the round-10 key is stored, the cache is marked valid. Later blocks take rounds 1–10 from the cache and leave the expansion registers frozen. Round 0 always comes straight from the stored cipher key. A key write clears the valid mark, including a write that lands in the middle of a block, so the next block recomputes. The round constant comes from a GF(2^8) doubling register, and the same register serves as the round index and the cache address.

Top module: `aes_rkey_cache`

## Requirements
- R1: After reset, `rk_vld` and `xp_busy` are low, `rk` is zero, and the cache counts as invalid, so the first block after reset runs the expansion.
- R2: A `blk_start` accepted while idle makes `rk_vld` high for exactly 11 consecutive cycles, starting on the next cycle, with `rk_idx` going 0, 1, … 10. When `rk_vld` is low, `rk` is zero.
- R3: The key presented with `rk_idx` = 0 is the cipher key written last before the block was accepted.
- R4: The key presented with `rk_idx` = r (1 to 10) is AES-128 round key r of that cipher key. Bit 127 is the first key byte's MSB, and word 0 is bits 127:96.
- R5: On a block that starts while the cache is invalid, `xp_busy` is high on all 11 presentation cycles. The cache becomes valid after the round-10 key is stored, unless a key write happened during that block.
- R6: On a block that starts with a valid cache, `xp_busy` stays low throughout, and the keys presented equal those of the block that filled the cache.
- R7: A `key_wr` during a block does not change the keys of rounds 1–10 still to come in that block. The next block runs the expansion on the new key.
- R8: `blk_start` is ignored while a block is being presented (including its round-10 cycle) and in any cycle where `key_wr` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_wr | input | 1 | Loads `key_in` as the new cipher key and invalidates the cache |
| key_in | input | 128 | Cipher key value |
| blk_start | input | 1 | Requests the round-key sequence for one block |
| rk_vld | output | 1 | A round key is being presented |
| rk_idx | output | 4 | Round number of the presented key |
| rk | output | 128 | Presented round key |
| xp_busy | output | 1 | Expansion logic is active this cycle |

## Verification
The assertions assume `key_wr` and `blk_start` are clean single-bit levels sampled at the clock edge, and that a block is consumed at one key per cycle with no back-pressure. The stimulus drives both inputs one half-period away from the sampling edge. It pulses them for one cycle, deliberately overlapping them with a running block, with each other, and with the round-10 cycle. A behavioural model in the bench predicts every output on every cycle. Its own byte substitution is found by inverse search, and its result is cross-checked against a known expansion table.

// File: rtl/rkc_pkg.sv
// Package: shared GF(2^8) arithmetic for the round-key scheduler.
// Assumes the AES reduction polynomial x^8+x^4+x^3+x+1.
package rkc_pkg;

    // Multiply by x in GF(2^8)
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General GF(2^8) product by shift-and-add
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = gf_dbl(aa);
        end
        return acc;
    endfunction

    // AES byte substitution: inverse as x^254, then the affine map
    function automatic logic [7:0] sbox_calc(input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        r = 8'h01;
        p = x;
        e = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
                 ^ {r[3:0], r[7:4]} ^ 8'h63;
    endfunction

    // Constant after n doublings of 01
    function automatic logic [7:0] rc_nth(input int n);
        logic [7:0] v;
        v = 8'h01;
        for (int i = 0; i < n; i++) v = gf_dbl(v);
        return v;
    endfunction

    // Position of a doubling-counter value in the sequence 01,02,...
    function automatic int rc_index(input logic [7:0] rc, input int n);
        int         idx;
        logic [7:0] v;
        idx = 0;
        v   = 8'h01;
        for (int i = 0; i <= n; i++) begin
            if (v == rc) idx = i;
            v = gf_dbl(v);
        end
        return idx;
    endfunction

endpackage

// File: rtl/rkc_subword.sv
// Module: substitutes each byte of a word through the AES S-box.
// Purely combinational; assumes its input comes straight from a register.
module rkc_subword #(
    parameter int WW = 32
) (
    input  logic [WW-1:0] w_in,
    output logic [WW-1:0] w_out
);
    localparam int NB = WW / 8;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        // One S-box per byte lane
        assign w_out[8*g +: 8] = rkc_pkg::sbox_calc(w_in[8*g +: 8]);
    end
endmodule

// File: rtl/rkc_expand.sv
// Module: AES-128 key expansion, one round key per enabled cycle.
// Holds the current round key and a registered S-box input word, so the
// S-boxes see only register outputs and never the feedback multiplexer.
// Assumes load and step are never high together.
module rkc_expand #(
    parameter int KW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [KW-1:0] key_in,
    input  logic [7:0]    rcon,
    output logic [KW-1:0] cur
);
    localparam int WW = 32;
    localparam int NW = KW / WW;

    logic [KW-1:0] cur_q;
    logic [WW-1:0] sin_q;
    logic [WW-1:0] sub_w;
    logic [WW-1:0] tmp_w;
    logic [KW-1:0] nxt;
    logic [KW-1:0] d;

    rkc_subword #(.WW(WW)) i_sub (.w_in(sin_q), .w_out(sub_w));

    // Next round key from current key and substituted rotated word
    always_comb begin
        tmp_w = sub_w ^ {rcon, {(WW-8){1'b0}}};
        nxt[KW-1 -: WW] = cur_q[KW-1 -: WW] ^ tmp_w;
        for (int i = 1; i < NW; i++)
            nxt[KW-1-WW*i -: WW] = cur_q[KW-1-WW*i -: WW] ^ nxt[KW-1-WW*(i-1) -: WW];
        d = load ? key_in : nxt;
    end

    // Expansion registers: clocked only when loading or stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            sin_q <= '0;
        end else if (load || step) begin
            cur_q <= d;
            sin_q <= {d[WW-9:0], d[WW-1 -: 8]};
        end
    end

    assign cur = cur_q;

    // The S-box input register always holds the rotated last word of the key
    p_sin_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load || step) |=> (sin_q == {cur_q[WW-9:0], cur_q[WW-1 -: 8]}));

    // With neither enable, the expansion state is frozen
    p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(cur_q) && $stable(sin_q)));
endmodule

// File: rtl/rkc_cache.sv
// Module: register cache of round keys 1..NRK, one write port, one read port.
// Slot 0 does not exist; round 0 comes from the key register at the top.
// Assumes the write address lies in 1..NRK whenever write is enabled.
module rkc_cache #(
    parameter int NRK = 10,
    parameter int KW  = 128,
    parameter int IW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [KW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [KW-1:0] rdata
);
    logic [KW-1:0] mem [1:NRK];

    // Store the presented key into the slot selected by the round index
    always_ff @(posedge clk) begin
        for (int g = 1; g <= NRK; g++)
            if (we && waddr == IW'(g)) mem[g] <= wdata;
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        for (int g = 1; g <= NRK; g++)
            if (raddr == IW'(g)) rdata = mem[g];
    end

    p_waddr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr >= IW'(1) && waddr <= IW'(NRK)));
endmodule

// File: rtl/aes_rkey_cache.sv
// Module: round-key scheduler with key cache and invalidation control.
// A block start presents round keys 0..NRK on consecutive cycles.
// On a cache miss the expansion runs alongside and fills the cache;
// on a hit the expansion is held and keys come from the cache.
// Assumes the consumer takes one key per cycle with no back-pressure.
module aes_rkey_cache #(
    parameter int NRK = 10,
    parameter int KW  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_wr,
    input  logic [KW-1:0]      key_in,
    input  logic               blk_start,
    output logic               rk_vld,
    output logic [3:0]         rk_idx,
    output logic [KW-1:0]      rk,
    output logic               xp_busy
);
    localparam int         IW      = 4;
    localparam logic [7:0] RC_LAST = rkc_pkg::rc_nth(NRK);

    logic [KW-1:0] key_q;
    logic          valid_q;
    logic          dirty_q;
    logic          run_q;
    logic          hit_q;
    logic [7:0]    rc_q;
    logic          accept;
    logic          last;
    logic [IW-1:0] idx;
    logic [KW-1:0] cur;
    logic [KW-1:0] cache_rd;

    assign accept = blk_start && !run_q && !key_wr;
    assign last   = run_q && (rc_q == RC_LAST);

    // Round index decoded from the doubling counter
    always_comb idx = IW'(rkc_pkg::rc_index(rc_q, NRK));

    // Key register, cache-valid flag and mid-block key-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q   <= '0;
            valid_q <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            if (key_wr) key_q <= key_in;
            if (key_wr)
                valid_q <= 1'b0;
            else if (last && !hit_q && !dirty_q)
                valid_q <= 1'b1;
            if (key_wr)
                dirty_q <= 1'b1;
            else if (accept)
                dirty_q <= 1'b0;
        end
    end

    // Block sequencer: doubling round-constant counter doubles as round index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            hit_q <= 1'b0;
            rc_q  <= 8'h01;
        end else if (accept) begin
            run_q <= 1'b1;
            hit_q <= valid_q;
            rc_q  <= 8'h01;
        end else if (run_q) begin
            if (last) run_q <= 1'b0;
            else      rc_q  <= rkc_pkg::gf_dbl(rc_q);
        end
    end

    rkc_expand #(.KW(KW)) i_expand (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept && !valid_q),
        .step   (run_q && !hit_q && !last),
        .key_in (key_q),
        .rcon   (rc_q),
        .cur    (cur)
    );

    rkc_cache #(.NRK(NRK), .KW(KW), .IW(IW)) i_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (run_q && !hit_q && idx != '0),
        .waddr  (idx),
        .wdata  (cur),
        .raddr  (idx),
        .rdata  (cache_rd)
    );

    // Output selection: key register, expansion register or cache
    always_comb begin
        if (!run_q)          rk = '0;
        else if (idx == '0)  rk = key_q;
        else if (hit_q)      rk = cache_rd;
        else                 rk = cur;
    end

    assign rk_vld  = run_q;
    assign rk_idx  = idx;
    assign xp_busy = run_q && !hit_q;

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_vld && rk_idx != IW'(NRK)) |=> (rk_vld && rk_idx == $past(rk_idx) + 1'b1));

    p_first_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rk_vld) |-> (rk_idx == '0));

    p_busy_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_vld && $past(rk_vld)) |-> (xp_busy == $past(xp_busy)));

    p_keywr_inval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> !valid_q);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start && key_wr && !rk_vld) |=> !rk_vld);
endmodule

// File: tb/test_aes_rkey_cache.sv
module test_aes_rkey_cache;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         key_wr;
    logic [127:0] key_in;
    logic         blk_start;
    logic         rk_vld;
    logic [3:0]   rk_idx;
    logic [127:0] rk;
    logic         xp_busy;

    int    n_vec = 0;
    int    n_bad = 0;
    string scen  = "R1";
    bit    armed = 1'b0;

    always #4 clk = ~clk;

    aes_rkey_cache i_aes_rkey_cache (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_in(key_in),
        .blk_start(blk_start), .rk_vld(rk_vld), .rk_idx(rk_idx),
        .rk(rk), .xp_busy(xp_busy)
    );

    localparam logic [127:0] FIPS_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    logic [127:0] fips_rk [0:10];

    // ---------------- behavioural reference ----------------
    function automatic logic [7:0] b_xt(input logic [7:0] a);
        return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
    endfunction
    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] s = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) s ^= x;
            x = b_xt(x);
        end
        return s;
    endfunction
    function automatic logic [7:0] b_sbox(input logic [7:0] x);
        logic [7:0] inv = 0;
        logic [7:0] o;
        logic [7:0] c = 8'h63;
        if (x != 0)
            for (int y = 1; y < 256; y++)
                if (b_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return o;
    endfunction

    logic [127:0] m_sched [0:10];
    logic [127:0] m_key, m_runkey;
    bit           m_run, m_hit, m_valid, m_dirty;
    int           m_idx;

    task automatic model_expand(input logic [127:0] k);
        logic [31:0] w [0:43];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {b_sbox(t[23:16]), b_sbox(t[15:8]), b_sbox(t[7:0]), b_sbox(t[31:24])};
                t = t ^ {rc, 24'h0};
                rc = b_xt(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r <= 10; r++)
            m_sched[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    // Reference state advance at each rising edge
    always @(posedge clk) begin
        bit was;
        armed = 1'b1;
        if (!rst_n) begin
            m_run = 0; m_hit = 0; m_valid = 0; m_dirty = 0; m_idx = 0; m_key = '0;
        end else begin
            was = m_run;
            if (m_run) begin
                if (m_idx == 10) begin
                    m_run = 0;
                    if (!m_hit && !m_dirty && !key_wr) m_valid = 1;
                end else m_idx++;
            end
            if (key_wr) begin
                m_key = key_in; m_valid = 0; m_dirty = 1;
            end else if (blk_start && !was) begin
                m_run = 1; m_hit = m_valid; m_idx = 0; m_dirty = 0;
                m_runkey = m_key;
                model_expand(m_key);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t act=%h exp=%h", req, scen, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (armed) begin
            chk(rk_vld == m_run, "R2 rk_vld", 128'(rk_vld), 128'(m_run));
            chk(xp_busy == (m_run && !m_hit), m_hit ? "R6 xp_busy" : "R5 xp_busy",
                128'(xp_busy), 128'(m_run && !m_hit));
            if (m_run) begin
                chk(rk_idx == 4'(m_idx), "R2 rk_idx", 128'(rk_idx), 128'(m_idx));
                chk(rk == m_sched[m_idx], (m_idx == 0) ? "R3 rk" : "R4 rk", rk, m_sched[m_idx]);
                if (m_runkey == FIPS_KEY)
                    chk(rk == fips_rk[m_idx], "R4 table", rk, fips_rk[m_idx]);
            end else
                chk(rk == '0, "R2 rk idle", rk, '0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_key(input logic [127:0] k);
        key_in = k; key_wr = 1'b1;
        @(negedge clk);
        key_wr = 1'b0;
    endtask
    task automatic pulse_start();
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
    endtask
    task automatic one_block();
        pulse_start();
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        fips_rk[0]  = FIPS_KEY;
        fips_rk[1]  = 128'ha0fafe1788542cb123a339392a6c7605;
        fips_rk[2]  = 128'hf2c295f27a96b9435935807a7359f67f;
        fips_rk[3]  = 128'h3d80477d4716fe3e1e237e446d7a883b;
        fips_rk[4]  = 128'hef44a541a8525b7fb671253bdb0bad00;
        fips_rk[5]  = 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
        fips_rk[6]  = 128'h6d88a37a110b3efddbf98641ca0093fd;
        fips_rk[7]  = 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
        fips_rk[8]  = 128'head27321b58dbad2312bf5607f8d292f;
        fips_rk[9]  = 128'hac7766f319fadc2128d12941575c006e;
        fips_rk[10] = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

        rst_n = 1'b0; key_wr = 1'b0; blk_start = 1'b0; key_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!rk_vld && !xp_busy && rk == '0, "R1 reset", {rk_vld, xp_busy, rk[125:0]}, '0);

        scen = "R1 first block after reset expands";
        one_block();

        scen = "R4 known vectors, miss then R6 hit";
        wr_key(FIPS_KEY);
        one_block();
        one_block();

        scen = "R8 start while running";
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (12) @(negedge clk);

        scen = "R8 start with key write same cycle";
        key_in = 128'h000102030405060708090a0b0c0d0e0f;
        key_wr = 1'b1; blk_start = 1'b1;
        @(negedge clk);
        key_wr = 1'b0; blk_start = 1'b0;
        repeat (3) @(negedge clk);
        one_block();
        one_block();

        scen = "R7 key write mid-block";
        pulse_start();
        repeat (5) @(negedge clk);
        wr_key('0);
        repeat (8) @(negedge clk);
        scen = "R7 next block recomputes";
        one_block();
        one_block();

        scen = "R8 start on round-10 cycle, R2 back to back";
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        pulse_start();
        repeat (12) @(negedge clk);

        scen = "R7 key write mid-hit-block";
        wr_key(FIPS_KEY);
        one_block();
        pulse_start();
        repeat (2) @(negedge clk);
        wr_key({4{32'hffffffff}});
        repeat (10) @(negedge clk);
        one_block();
        one_block();

        scen = "R4 pattern keys";
        for (int k = 0; k < 4; k++) begin
            wr_key({4{32'h9e3779b9 * (k + 1)}} ^ {32'(k), 96'h1});
            one_block();
            one_block();
        end

        scen = "R1 reset mid-block";
        pulse_start();
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        one_block();
        one_block();

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule